// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block is the device end of a host-resident receive ring. Software writes one configuration word that sets the run mode, the ring size as a power of two, the receive buffer size, where interrupts go and an idle timeout for closing buffers. It then hands over empty buffers by advancing a write index. The block fills the buffer at its read position from an incoming beat stream and issues one write request per beat, tagged with the descriptor index and the beat offset inside that buffer. When a buffer is closed, the block publishes the index of that buffer in a status word and, if enabled, raises an interrupt.

Several frames may share one buffer. A frame that does not fit in the space left in the buffer continues in the next descriptor. A buffer closes when it is full, when the idle timer expires, or when the channel is stopped or paused. The timer counts pulses of an external 32 µs tick. The channel reports idle once it is stopped or paused and nothing is left in flight.

Top module: `rx_ring_ctl`

## Requirements
- R1: After reset the channel is off. `chanIdle` is 1, and `frmReady`, `dmaValid`, `statusValid` and `irq` are 0.
- R2: A descriptor is available only while the read index and the posted write index differ, both taken modulo the ring size. When the two are equal, `frmReady` is 0, so at most ring size minus 1 buffers are outstanding.
- R3: A write index posted through `wrIdxWe` is taken only if its bits 2:0 are zero, meaning it is a multiple of 8. Any other value is ignored and the previous write index is kept.
- R4: Each beat accepted (`frmValid` and `frmReady` high at a clock edge) gives exactly one `dmaValid` pulse after that edge. The pulse carries the current descriptor index, the beat offset inside the buffer (counting from 0) and the beat data.
- R5: Config bits 17:16 set the buffer capacity: 00 is 4 KiB, 01 is 8 KiB, 10 is 12 KiB and 11 is 16 KiB, divided by BEAT_BYTES to give a beat count. The buffer closes on the beat that fills it. The rest of the frame continues at offset 0 of the next descriptor.
- R6: Each buffer close gives a `statusValid` pulse one cycle later. `statusWord` bits 11:0 then hold the closed index. The read index then advances and wraps at a ring size of 2^(config bits 23:20), clamped to 32 through 4096 entries.
- R7: Config bits 11:4 hold a timeout T. When T is nonzero and a buffer is partly filled, the T-th `usTick` pulse with no accepted beat closes the buffer. When T is 0, the timer is off. A tick has no effect while no buffer is open.
- R8: `irq` pulses together with `statusValid` only when config bits 13:12 equal 01. With 00, a close gives no interrupt.
- R9: Run mode in config bits 31:30 equal to 01 (pause at end of frame) keeps accepting beats of the frame in progress. It starts no new frame, and it closes the partly filled buffer in the cycle after the last beat.
- R10: Run mode 00 (and the unused code 11) drops `frmReady` in the cycle after the configuration write. Any open buffer closes at the next edge. Mode 10 is normal operation.
- R11: `chanIdle` is 1 exactly when the mode is not 10, no frame is in progress and no buffer is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration word write strobe |
| cfgData | input | 32 | Configuration word: mode 31:30, ring log 23:20, buffer size 17:16, interrupt target 13:12, timeout 11:4 |
| wrIdxWe | input | 1 | Write index post strobe |
| wrIdxData | input | 12 | Posted write index (one past last ready descriptor) |
| usTick | input | 1 | One-cycle pulse every 32 µs |
| frmValid | input | 1 | Frame beat valid |
| frmData | input | DATA_W | Frame beat data |
| frmLast | input | 1 | Last beat of frame |
| frmReady | output | 1 | Beat accepted when high with frmValid |
| dmaValid | output | 1 | Write request valid |
| dmaDesc | output | 12 | Descriptor index of the write |
| dmaBeat | output | OFF_W | Beat offset inside the buffer |
| dmaData | output | DATA_W | Write data |
| statusValid | output | 1 | Status write request (buffer closed) |
| statusWord | output | 32 | Bits 11:0 hold the last closed descriptor index |
| irq | output | 1 | Host interrupt pulse on close |
| chanIdle | output | 1 | Channel idle flag |

## Verification
The main function is driven with a long frame of 100 beats that crosses the edge of a 4 KiB buffer, which shows whether the frame spills into the next descriptor at offset 0. An 8 KiB frame is used to separate a capacity taken from the size field from a fixed 64-beat capacity. Many one-beat buffers are closed by the timer to walk the read index to the write index, then past the top of the ring. This tells apart the no-room condition, the wrap to 0, and write indices that were refused because they are not multiples of 8. Separate runs stop the channel mid-frame, either with the pause-at-end-of-frame mode or with the off mode. These runs show the difference between finishing a frame and cutting it, and whether the interrupt target field gates the interrupt.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EOF = 2'b01,
    MODE_RUN = 2'b10,
    MODE_RSV = 2'b11
  } runMode_e;

  // control -> datapath
  typedef struct packed {
    logic takeBeat;
    logic closeBuf;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic descAvail;
    logic bufOpen;
    logic lastSlot;
  } dpFlags_t;

endpackage

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  runMode_e         mode,
  input  logic [TMO_W-1:0] tmo,
  input  logic             frmValid,
  input  logic             frmLast,
  input  logic             usTick,
  input  dpFlags_t         flags,
  output dpStrobe_t        strb,
  output logic             frmReady,
  output logic             chanIdle
);

  logic             inFrame;
  logic [TMO_W-1:0] tmrCnt;
  logic             take;
  logic             stopNow;
  logic             drain;
  logic             tmoHit;
  logic             closeBuf;

  assign stopNow  = (mode == MODE_OFF) || (mode == MODE_RSV);
  assign frmReady = flags.descAvail &&
                    ((mode == MODE_RUN) || ((mode == MODE_EOF) && inFrame));
  assign take     = frmValid && frmReady;

  // flush a partial buffer when stopping, or once the frame ended in pause mode
  assign drain    = flags.bufOpen && !take &&
                    (stopNow || ((mode == MODE_EOF) && !inFrame));
  assign tmoHit   = flags.bufOpen && !take && usTick &&
                    (tmo != '0) && (tmrCnt == tmo - TMO_W'(1));
  assign closeBuf = (take && flags.lastSlot) || drain || tmoHit;

  assign strb.takeBeat = take;
  assign strb.closeBuf = closeBuf;

  assign chanIdle = (mode != MODE_RUN) && !inFrame && !flags.bufOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
    end else if (stopNow) begin
      inFrame <= 1'b0;
    end else if (take) begin
      inFrame <= !frmLast;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (take || closeBuf || !flags.bufOpen) begin
      tmrCnt <= '0;
    end else if (usTick) begin
      tmrCnt <= tmrCnt + TMO_W'(1);
    end
  end

endmodule

// File: rtl/rxr_dpath.sv
module rxr_dpath
  import rxr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BEAT_BYTES = 64,
  parameter int MIN_LOG    = 5,
  parameter int MAX_LOG    = 12,
  parameter int TMO_W      = 8,
  localparam int IDX_W     = MAX_LOG,
  localparam int BEATS_4K  = 4096 / BEAT_BYTES,
  localparam int MAX_BEATS = 4 * BEATS_4K,
  localparam int OFF_W     = $clog2(MAX_BEATS),
  localparam int FILL_W    = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [31:0]       cfgData,
  input  logic              wrIdxWe,
  input  logic [IDX_W-1:0]  wrIdxData,
  input  logic [DATA_W-1:0] frmData,
  input  dpStrobe_t         strb,
  output dpFlags_t          flags,
  output runMode_e          mode,
  output logic [TMO_W-1:0]  tmo,
  output logic              dmaValid,
  output logic [IDX_W-1:0]  dmaDesc,
  output logic [OFF_W-1:0]  dmaBeat,
  output logic [DATA_W-1:0] dmaData,
  output logic              statusValid,
  output logic [31:0]       statusWord,
  output logic              irq
);

  logic [3:0]        cfgLog;
  logic [1:0]        cfgBsel;
  logic [1:0]        cfgIrq;
  logic [3:0]        effLog;
  logic [IDX_W-1:0]  ringMask;
  logic [IDX_W-1:0]  rdIdx;
  logic [IDX_W-1:0]  wrIdx;
  logic [IDX_W-1:0]  rdMasked;
  logic [FILL_W-1:0] fill;
  logic [FILL_W-1:0] capBeats;

  // config register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= MODE_OFF;
      cfgLog  <= '0;
      cfgBsel <= '0;
      cfgIrq  <= '0;
      tmo     <= '0;
    end else if (cfgWe) begin
      mode    <= runMode_e'(cfgData[31:30]);
      cfgLog  <= cfgData[23:20];
      cfgBsel <= cfgData[17:16];
      cfgIrq  <= cfgData[13:12];
      tmo     <= cfgData[4 +: TMO_W];
    end
  end

  // ring size, clamped to the legal range
  always_comb begin
    if (cfgLog < 4'(MIN_LOG))      effLog = 4'(MIN_LOG);
    else if (cfgLog > 4'(MAX_LOG)) effLog = 4'(MAX_LOG);
    else                           effLog = cfgLog;
  end

  for (genvar i = 0; i < IDX_W; i++) begin : g_mask
    assign ringMask[i] = (32'(effLog) > i);
  end

  assign rdMasked = rdIdx & ringMask;
  assign capBeats = FILL_W'(BEATS_4K) * (FILL_W'(cfgBsel) + FILL_W'(1));

  assign flags.descAvail = ((rdIdx ^ wrIdx) & ringMask) != '0;
  assign flags.bufOpen   = (fill != '0);
  assign flags.lastSlot  = ((fill + FILL_W'(1)) == capBeats);

  // write index: only multiples of 8 are taken
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
    end else if (wrIdxWe && (wrIdxData[2:0] == 3'b000)) begin
      wrIdx <= wrIdxData;
    end
  end

  // read index and fill level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdx <= '0;
      fill  <= '0;
    end else if (strb.closeBuf) begin
      rdIdx <= (rdIdx + IDX_W'(1)) & ringMask;
      fill  <= '0;
    end else if (strb.takeBeat) begin
      fill  <= fill + FILL_W'(1);
    end
  end

  // write request and status outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaValid    <= 1'b0;
      dmaDesc     <= '0;
      dmaBeat     <= '0;
      dmaData     <= '0;
      statusValid <= 1'b0;
      statusWord  <= '0;
      irq         <= 1'b0;
    end else begin
      dmaValid    <= strb.takeBeat;
      statusValid <= strb.closeBuf;
      irq         <= strb.closeBuf && (cfgIrq == 2'b01);
      if (strb.takeBeat) begin
        dmaDesc <= rdMasked;
        dmaBeat <= fill[OFF_W-1:0];
        dmaData <= frmData;
      end
      if (strb.closeBuf) begin
        statusWord <= {{(32 - IDX_W){1'b0}}, rdMasked};
      end
    end
  end

endmodule

// File: rtl/rx_ring_ctl.sv
module rx_ring_ctl
  import rxr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BEAT_BYTES = 64,
  parameter int MIN_LOG    = 5,
  parameter int MAX_LOG    = 12,
  parameter int TMO_W      = 8,
  localparam int IDX_W     = MAX_LOG,
  localparam int OFF_W     = $clog2(4 * (4096 / BEAT_BYTES))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [31:0]       cfgData,
  input  logic              wrIdxWe,
  input  logic [IDX_W-1:0]  wrIdxData,
  input  logic              usTick,
  input  logic              frmValid,
  input  logic [DATA_W-1:0] frmData,
  input  logic              frmLast,
  output logic              frmReady,
  output logic              dmaValid,
  output logic [IDX_W-1:0]  dmaDesc,
  output logic [OFF_W-1:0]  dmaBeat,
  output logic [DATA_W-1:0] dmaData,
  output logic              statusValid,
  output logic [31:0]       statusWord,
  output logic              irq,
  output logic              chanIdle
);

  dpStrobe_t        strb;
  dpFlags_t         flags;
  runMode_e         mode;
  logic [TMO_W-1:0] tmo;

  rxr_ctrl #(.TMO_W(TMO_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (mode),
    .tmo      (tmo),
    .frmValid (frmValid),
    .frmLast  (frmLast),
    .usTick   (usTick),
    .flags    (flags),
    .strb     (strb),
    .frmReady (frmReady),
    .chanIdle (chanIdle)
  );

  rxr_dpath #(
    .DATA_W     (DATA_W),
    .BEAT_BYTES (BEAT_BYTES),
    .MIN_LOG    (MIN_LOG),
    .MAX_LOG    (MAX_LOG),
    .TMO_W      (TMO_W)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .cfgData     (cfgData),
    .wrIdxWe     (wrIdxWe),
    .wrIdxData   (wrIdxData),
    .frmData     (frmData),
    .strb        (strb),
    .flags       (flags),
    .mode        (mode),
    .tmo         (tmo),
    .dmaValid    (dmaValid),
    .dmaDesc     (dmaDesc),
    .dmaBeat     (dmaBeat),
    .dmaData     (dmaData),
    .statusValid (statusValid),
    .statusWord  (statusWord),
    .irq         (irq)
  );

endmodule

// File: rtl/rx_ring_ctl_chk.sv
module rx_ring_ctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic [1:0] cfgMode,
  input logic       frmValid,
  input logic       frmReady,
  input logic       dmaValid,
  input logic       statusValid,
  input logic       irq,
  input logic       chanIdle
);

  // R10
  off_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && (cfgMode == 2'b00)) |=> !frmReady);

  // R8
  irq_with_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> statusValid);

  // R4
  beat_to_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmReady) |=> dmaValid);

  // R4
  no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(frmValid && frmReady) |=> !dmaValid);

  // R11
  idle_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanIdle |-> !frmReady);

endmodule

bind rx_ring_ctl rx_ring_ctl_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWe       (cfgWe),
  .cfgMode     (cfgData[31:30]),
  .frmValid    (frmValid),
  .frmReady    (frmReady),
  .dmaValid    (dmaValid),
  .statusValid (statusValid),
  .irq         (irq),
  .chanIdle    (chanIdle)
);

// File: tb/rx_ring_ctl_tb_top.sv
`timescale 1ns/1ps
module rx_ring_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgData = '0;
  logic        wrIdxWe = 1'b0;
  logic [11:0] wrIdxData = '0;
  logic        usTick = 1'b0;
  logic        frmValid = 1'b0;
  logic [31:0] frmData = '0;
  logic        frmLast = 1'b0;
  logic        frmReady;
  logic        dmaValid;
  logic [11:0] dmaDesc;
  logic [7:0]  dmaBeat;
  logic [31:0] dmaData;
  logic        statusValid;
  logic [31:0] statusWord;
  logic        irq;
  logic        chanIdle;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  rx_ring_ctl dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .wrIdxWe(wrIdxWe), .wrIdxData(wrIdxData), .usTick(usTick),
    .frmValid(frmValid), .frmData(frmData), .frmLast(frmLast),
    .frmReady(frmReady), .dmaValid(dmaValid), .dmaDesc(dmaDesc),
    .dmaBeat(dmaBeat), .dmaData(dmaData), .statusValid(statusValid),
    .statusWord(statusWord), .irq(irq), .chanIdle(chanIdle)
  );

  function automatic logic [31:0] mkCfg(input logic [1:0] m, input logic [3:0] lg,
                                        input logic [1:0] bs, input logic [1:0] iq,
                                        input logic [7:0] t);
    return {m, 6'b0, lg, 2'b0, bs, 2'b0, iq, t, 4'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // all tasks start and end at a falling edge
  task automatic cfgWrite(input logic [31:0] v);
    cfgWe = 1'b1; cfgData = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic postWr(input logic [11:0] v);
    wrIdxWe = 1'b1; wrIdxData = v;
    @(negedge clk);
    wrIdxWe = 1'b0;
  endtask

  task automatic tick();
    usTick = 1'b1;
    @(negedge clk);
    usTick = 1'b0;
  endtask

  task automatic sendBeat(input bit last, input int expDesc, input int expOff,
                          input bit expClose, input bit expIrq, input string req);
    logic [31:0] d;
    d = {expDesc[11:0], expOff[7:0], 12'hA5C};
    frmValid = 1'b1; frmLast = last; frmData = d;
    @(negedge clk);
    frmValid = 1'b0; frmLast = 1'b0;
    chk(dmaValid && dmaDesc == 12'(expDesc) && dmaBeat == 8'(expOff) && dmaData == d,
        req, "beat desc/offset", {dmaDesc, dmaBeat}, {expDesc[11:0], expOff[7:0]});
    chk(statusValid == expClose, req, "close on beat", statusValid, expClose);
    if (expClose) begin
      chk(statusWord[11:0] == 12'(expDesc), "R6", "closed index", statusWord[11:0], expDesc);
      chk(irq == expIrq, "R8", "irq on close", irq, expIrq);
    end
  endtask

  // one-beat buffer closed by the 3-tick timeout
  task automatic oneBuf(input int d);
    sendBeat(1'b1, d, 0, 1'b0, 1'b0, "R4");
    tick(); tick();
    chk(statusValid == 1'b0, "R7", "early close", statusValid, 0);
    tick();
    chk(statusValid && statusWord[11:0] == 12'(d), "R7", "timeout close index",
        statusWord[11:0], d);
  endtask

  task automatic tReset();
    chk(chanIdle && !frmReady && !statusValid && !irq && !dmaValid, "R1", "reset outputs",
        {chanIdle, frmReady, statusValid, irq, dmaValid}, 5'b10000);
  endtask

  task automatic tPost();
    cfgWrite(mkCfg(2'b10, 4'd5, 2'b00, 2'b01, 8'd0));
    chk(!frmReady, "R2", "ready with equal indices", frmReady, 0);
    postWr(12'd3);
    chk(!frmReady, "R3", "misaligned index ignored", frmReady, 0);
    postWr(12'd8);
    chk(frmReady, "R3", "aligned index taken", frmReady, 1);
  endtask

  task automatic tSpill();
    for (int b = 0; b < 100; b++)
      sendBeat(b == 99, (b < 64) ? 0 : 1, b % 64, b == 63, 1'b1, "R5");
  endtask

  task automatic tTimeout();
    cfgWrite(mkCfg(2'b10, 4'd5, 2'b00, 2'b01, 8'd3));
    tick();
    chk(!statusValid, "R7", "tick 1", statusValid, 0);
    tick();
    chk(!statusValid, "R7", "tick 2", statusValid, 0);
    tick();
    chk(statusValid && statusWord[11:0] == 12'd1 && irq, "R7", "tick 3 closes",
        statusWord[11:0], 1);
    tick(); tick(); tick();
    chk(!statusValid, "R7", "tick with no open buffer", statusValid, 0);
  endtask

  task automatic tBig();
    cfgWrite(mkCfg(2'b10, 4'd5, 2'b01, 2'b01, 8'd3));
    for (int b = 0; b < 128; b++)
      sendBeat(b == 127, 2, b, b == 127, 1'b1, "R5");
  endtask

  task automatic tRing();
    for (int d = 3; d < 8; d++) oneBuf(d);
    chk(!frmReady, "R2", "no room at rd==wr", frmReady, 0);
    postWr(12'd0);
    chk(frmReady, "R2", "room after post", frmReady, 1);
    for (int d = 8; d < 32; d++) oneBuf(d);
    chk(!frmReady, "R6", "wrapped to wr=0", frmReady, 0);
    postWr(12'd8);
    oneBuf(0);
  endtask

  task automatic tPauseEof();
    cfgWrite(mkCfg(2'b10, 4'd5, 2'b00, 2'b01, 8'd0));
    for (int b = 0; b < 3; b++) sendBeat(1'b0, 1, b, 1'b0, 1'b0, "R9");
    cfgWrite(mkCfg(2'b01, 4'd5, 2'b00, 2'b01, 8'd0));
    chk(frmReady, "R9", "frame continues", frmReady, 1);
    sendBeat(1'b1, 1, 3, 1'b0, 1'b0, "R9");
    chk(!frmReady, "R9", "no new frame", frmReady, 0);
    @(negedge clk);
    chk(statusValid && statusWord[11:0] == 12'd1, "R9", "partial close", statusWord[11:0], 1);
    chk(chanIdle, "R11", "idle after pause", chanIdle, 1);
  endtask

  task automatic tOff();
    cfgWrite(mkCfg(2'b10, 4'd5, 2'b00, 2'b00, 8'd0));
    for (int b = 0; b < 2; b++) sendBeat(1'b0, 2, b, 1'b0, 1'b0, "R10");
    cfgWrite(32'h0);
    chk(!frmReady, "R10", "stopped", frmReady, 0);
    chk(!chanIdle, "R11", "busy with open buffer", chanIdle, 0);
    @(negedge clk);
    chk(statusValid && statusWord[11:0] == 12'd2, "R10", "stop closes buffer",
        statusWord[11:0], 2);
    chk(!irq, "R8", "no irq with target none", irq, 0);
    chk(chanIdle, "R11", "idle after stop", chanIdle, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPost();
    tSpill();
    tTimeout();
    tBig();
    tRing();
    tPauseEof();
    tOff();
    finishRun();
  end

endmodule